// File: doc/BRIEF.md
# Phase-Window Standby Clock Conditioner

This block watches two clocks of equal frequency whose relative phase is unknown and may wander, and keeps the clock that is not currently in use (the standby clock) at a phase of at least a quarter period away from the clock in use (the active clock). Both clocks are sampled by a fast clock running at four or more times their rate. The block measures how long the exclusive-OR of the two conditioned clocks is high over a fixed number of active-clock periods. If that high time shows the two clocks sitting closer than a quarter period, the block inverts the standby clock, which moves it by half a period.

A downstream glitch-free multiplexer can then change over between the active clock and the conditioned standby clock without two edges landing close together. A change-over request is honoured only while the latest measurement is clean. After every inversion the block withholds that status for a whole fresh measurement interval. Each clock keeps its own inversion flag, so a flag travels with its clock across change-overs, and only the flag of the current standby clock can ever change.

Top module: `phase_window_inverter`

## Requirements
- R1: While reset is low, clock A is active (`active_sel`=0), both inversion flags are clear (`standby_inv`=0) and `meas_valid` is 0.
- R2: A measurement starts at a rising edge of the synchronized active clock and ends on the N_PER-th following rising edge. Over that span the block counts fast-clock samples (total) and the samples where the XOR of the two conditioned, synchronized clocks is high (xor). The standby flag is inverted exactly when 2*xor + HYST < total.
- R3: After an inversion, a steady pair of clocks brings no further flag change: the conditioned standby clock then lies inside the quarter-to-three-quarter period window.
- R4: A clock pair whose offset lies below a quarter period but whose count still satisfies 2*xor + HYST >= total is left uninverted (hysteresis band).
- R5: Only the flag of the current standby clock ever changes. The flag of the active clock is held, and is seen unchanged once that clock becomes standby again.
- R6: After every inversion, `meas_valid` is 0 for at least N_PER full clock periods. It returns to 1 at the end of the first complete measurement that needs no inversion. That measurement starts after the inversion.
- R7: `sel_req` names the wanted active clock (0 = A, 1 = B, synchronous to `clk_fast`). `active_sel` follows it one fast cycle later, but only while `meas_valid` is 1 and no inversion occurs in that cycle. Otherwise `active_sel` holds.
- R8: `clk_standby` equals the raw standby clock (clock B when `active_sel`=0, clock A when 1) XOR that clock's inversion flag. `standby_inv` shows that flag.
- R9: A change-over leaves both flags unchanged, so after switching to B, `standby_inv` shows the flag of clock A (0 if A was never inverted).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Sampling clock, at least four times the clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_a | input | 1 | Clock A |
| clk_b | input | 1 | Clock B, same frequency as A, any phase |
| sel_req | input | 1 | Requested active clock, 0 = A, 1 = B |
| clk_standby | output | 1 | Conditioned standby clock |
| standby_inv | output | 1 | Inversion flag of the standby clock |
| meas_valid | output | 1 | Latest measurement is clean and complete |
| active_sel | output | 1 | Acknowledged active clock, 0 = A, 1 = B |

## Verification
The hardest case to reach is a flag change on clock A. It needs clock B to be active, and the phase must then move so that A falls too close to an already inverted B. The stimulus gets there in steps: it first forces an inversion of B, then requests the change-over, and then shifts B's delay by half a period. The bench then switches back and confirms that B's flag survived untouched. The hysteresis band is reached by sweeping every offset in whole sample steps, with a margin large enough that one off-window offset falls inside it.

// File: rtl/pwsel_pkg.sv
// Package: shared types for the phase-window standby clock conditioner.
// Assumes nothing beyond IEEE 1800-2017.
package pwsel_pkg;

    // Identity of a clock source; also the encoding of the active selection.
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

endpackage

// File: rtl/pwsel_sync.sv
// Module: multi-stage synchronizer for a vector of level signals.
// Assumes: each bit is an independent level, sampled into clk domain.
module pwsel_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pwsel_phase_meter.sv
// Module: counts samples and XOR-high samples over N_PER reference periods.
// Assumes: ref_lvl and xor_lvl are already in the clk domain. A restart
// drops the running interval and re-arms on the next reference rising edge.
// done is combinational and valid together with total_cnt/xor_cnt.
module pwsel_phase_meter #(
    parameter int N_PER      = 16,
    parameter int MAX_PERIOD = 64,
    localparam int MAXC      = N_PER * MAX_PERIOD,
    localparam int CW        = $clog2(MAXC + 1),
    localparam int EW        = $clog2(N_PER + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          ref_lvl,
    input  logic          xor_lvl,
    output logic          done,
    output logic [CW-1:0] total_cnt,
    output logic [CW-1:0] xor_cnt
);

    localparam logic [CW-1:0] CNT_MAX  = CW'(MAXC);
    localparam logic [EW-1:0] LAST_EDG = EW'(N_PER - 1);

    logic          ref_d;
    logic          armed;
    logic [EW-1:0] edges;
    logic          rise;

    assign rise = ref_lvl & ~ref_d;
    assign done = armed & rise & (edges == LAST_EDG);

    // Previous reference level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_d <= 1'b0;
        else        ref_d <= ref_lvl;
    end

    // Interval sequencing and sample counting.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            armed     <= 1'b0;
            edges     <= '0;
            total_cnt <= '0;
            xor_cnt   <= '0;
        end else if (rise && (!armed || done)) begin
            armed     <= 1'b1;
            edges     <= '0;
            total_cnt <= CW'(1);
            xor_cnt   <= CW'(xor_lvl);
        end else if (armed) begin
            if (rise) edges <= edges + 1'b1;
            if (total_cnt != CNT_MAX) total_cnt <= total_cnt + 1'b1;
            if (xor_lvl && xor_cnt != CNT_MAX) xor_cnt <= xor_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwsel_window_judge.sv
// Module: decides whether the measured XOR duty puts the clocks too close.
// Assumes: equal-duty clocks; duty below one half means the offset is
// under a quarter period. HYST widens the band that is left alone.
module pwsel_window_judge #(
    parameter int CW   = 8,
    parameter int HYST = 8
) (
    input  logic [CW-1:0] total_cnt,
    input  logic [CW-1:0] xor_cnt,
    output logic          too_close
);

    localparam logic [CW+1:0] HYST_V = (CW+2)'(HYST);

    logic [CW+1:0] lhs;
    logic [CW+1:0] rhs;

    // Compare twice the XOR count plus margin against the period sample count.
    always_comb begin
        lhs       = {1'b0, xor_cnt, 1'b0} + HYST_V;
        rhs       = {2'b00, total_cnt};
        too_close = lhs < rhs;
    end

endmodule

// File: rtl/phase_window_inverter.sv
// Module: top of the standby clock conditioner. Synchronizes both clocks,
// measures their conditioned phase relation and inverts the standby clock
// when it sits within a quarter period of the active one.
// Assumes: clk_a and clk_b share one frequency with 50% duty; clk_fast is at
// least four times faster; sel_req is synchronous to clk_fast.
module phase_window_inverter
    import pwsel_pkg::*;
#(
    parameter int N_PER       = 16,
    parameter int MAX_PERIOD  = 64,
    parameter int HYST        = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(N_PER * MAX_PERIOD + 1)
) (
    input  logic clk_fast,
    input  logic rst_n,
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel_req,
    output logic clk_standby,
    output logic standby_inv,
    output logic meas_valid,
    output logic active_sel
);

    src_e          act_q;
    logic          inv_a;
    logic          inv_b;
    logic [1:0]    raw_s;
    logic          ca_s;
    logic          cb_s;
    logic          ref_lvl;
    logic          xor_lvl;
    logic          done;
    logic [CW-1:0] total_cnt;
    logic [CW-1:0] xor_cnt;
    logic          too_close;
    logic          inv_fire;
    logic          switch_go;
    logic          restart;

    pwsel_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .d     ({clk_b, clk_a}),
        .q     (raw_s)
    );

    // Conditioned synchronized clocks, active reference and phase XOR.
    always_comb begin
        ca_s    = raw_s[0] ^ inv_a;
        cb_s    = raw_s[1] ^ inv_b;
        ref_lvl = (act_q == SRC_B) ? cb_s : ca_s;
        xor_lvl = ca_s ^ cb_s;
    end

    pwsel_phase_meter #(
        .N_PER      (N_PER),
        .MAX_PERIOD (MAX_PERIOD)
    ) u_meter (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .restart   (restart),
        .ref_lvl   (ref_lvl),
        .xor_lvl   (xor_lvl),
        .done      (done),
        .total_cnt (total_cnt),
        .xor_cnt   (xor_cnt)
    );

    pwsel_window_judge #(
        .CW   (CW),
        .HYST (HYST)
    ) u_judge (
        .total_cnt (total_cnt),
        .xor_cnt   (xor_cnt),
        .too_close (too_close)
    );

    // Decisions for this cycle: inversion wins over a change-over.
    always_comb begin
        inv_fire  = done & too_close;
        switch_go = meas_valid & (sel_req != act_q) & ~inv_fire;
        restart   = inv_fire | switch_go;
    end

    // Inversion flags: only the standby clock's flag may flip.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            inv_a <= 1'b0;
            inv_b <= 1'b0;
        end else if (inv_fire) begin
            if (act_q == SRC_B) inv_a <= ~inv_a;
            else                inv_b <= ~inv_b;
        end
    end

    // Measurement status: cleared by an inversion, set by a clean interval.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)        meas_valid <= 1'b0;
        else if (inv_fire) meas_valid <= 1'b0;
        else if (done)     meas_valid <= 1'b1;
    end

    // Active selection follows the request when allowed.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)         act_q <= SRC_A;
        else if (switch_go) act_q <= (act_q == SRC_A) ? SRC_B : SRC_A;
    end

    // Outputs: conditioned raw standby clock and its flag.
    always_comb begin
        active_sel  = (act_q == SRC_B);
        clk_standby = active_sel ? (clk_a ^ inv_a) : (clk_b ^ inv_b);
        standby_inv = active_sel ? inv_a : inv_b;
    end

endmodule

// File: rtl/phase_window_inverter_chk.sv
// Module: assertion checker bound to phase_window_inverter.
// Assumes: the clock period is at least four fast samples.
module phase_window_inverter_chk #(
    parameter int N_PER      = 16,
    parameter int MAX_PERIOD = 64,
    localparam int MIN_QUIET = N_PER * 4 - 4,
    localparam int QW        = $clog2(MIN_QUIET + 2)
) (
    input logic clk_fast,
    input logic rst_n,
    input logic active_sel,
    input logic standby_inv,
    input logic meas_valid,
    input logic inv_a,
    input logic inv_b
);

    logic          prev_a;
    logic          prev_b;
    logic          flip;
    logic [QW-1:0] quiet_cnt;

    assign flip = (inv_a != prev_a) | (inv_b != prev_b);

    // Track flag history and cycles since the last flag flip.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            prev_a    <= 1'b0;
            prev_b    <= 1'b0;
            quiet_cnt <= '0;
        end else begin
            prev_a <= inv_a;
            prev_b <= inv_b;
            if (flip)                          quiet_cnt <= '0;
            else if (quiet_cnt < QW'(MIN_QUIET)) quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assert_switch_needs_valid_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (active_sel != $past(active_sel)) |-> $past(meas_valid));

    assert_flip_clears_valid_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        ((standby_inv != $past(standby_inv)) && (active_sel == $past(active_sel))) |-> !meas_valid);

    assert_valid_after_quiet_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        meas_valid |-> (quiet_cnt >= QW'(MIN_QUIET)));

    assert_active_a_held_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (!active_sel && !$past(active_sel)) |-> (inv_a == $past(inv_a)));

    assert_active_b_held_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (active_sel && $past(active_sel)) |-> (inv_b == $past(inv_b)));

endmodule

bind phase_window_inverter phase_window_inverter_chk #(
    .N_PER      (N_PER),
    .MAX_PERIOD (MAX_PERIOD)
) u_chk (
    .clk_fast    (clk_fast),
    .rst_n       (rst_n),
    .active_sel  (active_sel),
    .standby_inv (standby_inv),
    .meas_valid  (meas_valid),
    .inv_a       (inv_a),
    .inv_b       (inv_b)
);

// File: tb/phase_window_inverter_bench.sv
// Bench: sweeps every clock offset at 16 samples per period, then walks a
// change-over scenario. Expected flags follow from R2: with N_PER=4,
// period 16, the XOR count is 8*m (m = offset distance), total 64,
// so inversion happens iff 16*m + 20 < 64, i.e. m <= 2.
module phase_window_inverter_bench;

    localparam int P     = 16;
    localparam int NP    = 4;
    localparam int HY    = 20;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n;
    logic clk_a;
    logic clk_b;
    logic sel_req;
    logic clk_standby;
    logic standby_inv;
    logic meas_valid;
    logic active_sel;

    int   checks = 0;
    int   errors = 0;
    int   delay_b = 0;
    bit   done_flag = 1'b0;

    initial forever #4 clk = ~clk;

    phase_window_inverter #(
        .N_PER      (NP),
        .MAX_PERIOD (P),
        .HYST       (HY)
    ) u_phase_window_inverter (
        .clk_fast    (clk),
        .rst_n       (rst_n),
        .clk_a       (clk_a),
        .clk_b       (clk_b),
        .sel_req     (sel_req),
        .clk_standby (clk_standby),
        .standby_inv (standby_inv),
        .meas_valid  (meas_valid),
        .active_sel  (active_sel)
    );

    // Clock pattern generator: A at phase 0, B delayed by delay_b samples.
    initial begin
        int t;
        t = 0;
        clk_a = 1'b0;
        clk_b = 1'b0;
        forever begin
            @(posedge clk);
            t = (t + 1) % P;
            clk_a <= (t < P/2);
            clk_b <= (((t - delay_b + P) % P) < P/2);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Compare clk_standby with the raw standby clock XOR expected flag (R8).
    task automatic check_wave(input bit use_a, input bit flag);
        int bad;
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (clk_standby !== ((use_a ? clk_a : clk_b) ^ flag)) bad++;
        end
        check(bad == 0, "R8 standby waveform", bad, 0);
    endtask

    // Monitor for R6: valid stays low at least NP*P cycles after a flip.
    initial begin
        bit prev_inv;
        bit prev_act;
        bit prev_rst;
        bit watching;
        int low_cnt;
        prev_inv = 0; prev_act = 0; prev_rst = 0; watching = 0; low_cnt = 0;
        forever begin
            @(negedge clk);
            if (rst_n !== 1'b1 || prev_rst !== 1'b1) begin
                watching = 0;
            end else if (standby_inv != prev_inv && active_sel == prev_act) begin
                check(meas_valid == 1'b0, "R6 valid at flip", meas_valid, 0);
                watching = 1;
                low_cnt  = 1;
            end else if (watching) begin
                if (meas_valid) begin
                    check(low_cnt >= NP * P, "R6 low interval", low_cnt, NP * P);
                    watching = 0;
                end else begin
                    low_cnt++;
                end
            end
            prev_inv = standby_inv;
            prev_act = active_sel;
            prev_rst = rst_n;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", LIMIT, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        sel_req = 1'b0;
        repeat (6) @(negedge clk);
        // R1: reset state
        check(active_sel == 1'b0, "R1 active_sel", active_sel, 0);
        check(standby_inv == 1'b0, "R1 standby_inv", standby_inv, 0);
        check(meas_valid == 1'b0, "R1 meas_valid", meas_valid, 0);

        // R7: request before any clean measurement is not acknowledged
        sel_req = 1'b1;
        rst_n   = 1'b1;
        repeat (20) @(negedge clk);
        check(meas_valid == 1'b0, "R7 valid still low", meas_valid, 0);
        check(active_sel == 1'b0, "R7 no ack while invalid", active_sel, 0);
        sel_req = 1'b0;

        // R2/R4/R3: sweep every offset with A active
        for (int d = 0; d < P; d++) begin
            int  m;
            bit  exp;
            string tag;
            delay_b = d;
            do_reset();
            m   = (d < P - d) ? d : P - d;
            exp = (16 * m + HY < NP * P);
            tag = (m == 3) ? "R4 hysteresis band" : "R2 window decision";
            repeat (700) @(negedge clk);
            check(standby_inv == exp, tag, standby_inv, exp);
            check(meas_valid == 1'b1, "R6 valid after clean interval", meas_valid, 1);
            check_wave(1'b0, exp);
            repeat (300) @(negedge clk);
            check(standby_inv == exp, "R3 flag stable", standby_inv, exp);
        end

        // Change-over scenario
        delay_b = 2;
        do_reset();
        repeat (700) @(negedge clk);
        check(standby_inv == 1'b1, "R2 B inverted", standby_inv, 1);
        sel_req = 1'b1;
        repeat (3) @(negedge clk);
        check(active_sel == 1'b1, "R7 ack while valid", active_sel, 1);
        check(standby_inv == 1'b0, "R9 A flag carried", standby_inv, 0);
        // Shift B so that A sits too close to the inverted B
        delay_b = 10;
        repeat (800) @(negedge clk);
        check(standby_inv == 1'b1, "R5 standby A inverted", standby_inv, 1);
        check(meas_valid == 1'b1, "R6 valid with B active", meas_valid, 1);
        check_wave(1'b1, 1'b1);
        sel_req = 1'b0;
        repeat (3) @(negedge clk);
        check(active_sel == 1'b0, "R7 switch back", active_sel, 0);
        check(standby_inv == 1'b1, "R5 B flag untouched while active", standby_inv, 1);
        repeat (700) @(negedge clk);
        check(standby_inv == 1'b1, "R3 no further flip", standby_inv, 1);
        check(meas_valid == 1'b1, "R6 valid steady", meas_valid, 1);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule